// File: doc/BRIEF.md
# Clocked Serial Byte Receiver with Clock Parking

This block receives bytes over a clocked serial link. A serial clock and a data input carry eight bits per byte. The serial clock can come from either of two sources. In internal mode the block generates it on `sck_out` at a fixed rate. In external mode a remote master drives it on `sck_in`. Software picks the receive mode, the clock source and the bit order, then raises `cfg_start`.

Each bit is sampled on a rising serial-clock edge. After eight bits, the byte goes into a one-entry receive buffer and `irq` pulses for one cycle. The buffer drains through a valid/ready port. `rx_valid` stays high and `rx_data` stays unchanged until a cycle with both `rx_valid` and `rx_ready` high. That cycle is the read.

Back-pressure works differently for the two clock sources. With the internal clock, a full buffer parks `sck_out` high, so the remote sender stalls. No data is lost. With the external clock the master cannot be stalled. A byte that completes while the buffer is still full is dropped, and a sticky overrun flag is raised.

External clock and data pass through two-flop synchronizers before any edge is detected. For this reason the system clock must run at least four times faster than the serial clock.

Top module: `ssr_rx`

## Requirements
- R1: The block receives only while `cfg_start` is 1 and `cfg_mode` is 2'b01. With any other mode value, `busy` stays 0, no byte is taken in, and `sck_out` stays high.
- R2: Data is sampled on rising serial-clock edges. With `cfg_lsb_first` = 0, the first bit received ends up in `rx_data[7]` and the last in `rx_data[0]`.
- R3: With `cfg_lsb_first` = 1, the first bit received ends up in `rx_data[0]` and the last in `rx_data[7]`.
- R4: `busy` rises in the same cycle the serial clock is seen to fall for the first time. With the internal clock, that first falling edge comes no later than 2*HALF cycles after the start.
- R5: `shifting` is 1 from the first falling edge of a byte until that byte's eighth falling edge, and is 0 after the eighth falling edge. Whenever `shifting` is 1, `busy` is 1.
- R6: On the eighth rising edge, the received byte is copied to `rx_data`, `rx_valid` rises, and `irq` pulses high for exactly one cycle.
- R7: Once `rx_valid` is 1, it stays 1 and `rx_data` stays unchanged until a cycle with `rx_valid` and `rx_ready` both 1. That cycle clears `rx_valid`.
- R8: With the internal clock (`cfg_ext_clk` = 0), `sck_out` is held high for as long as `rx_valid` is 1. After a read, the next falling edge arrives within 2*HALF+1 cycles.
- R9: With the external clock, a byte that completes while `rx_valid` is 1 and no read happens leaves `rx_data` unchanged, gives no `irq`, and sets `rx_ovr`. `rx_ovr` stays set until a cycle with `ovr_clr` = 1.
- R10: If `cfg_start` is cleared in the middle of a byte, that byte still completes and is delivered. `busy` then falls, and no further byte is received.
- R11: Right after reset, `rx_valid`, `irq`, `busy`, `shifting` and `rx_ovr` are 0 and `sck_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Operating mode; 2'b01 selects receive |
| cfg_ext_clk | input | 1 | 1: serial clock from `sck_in`; 0: generated on `sck_out` |
| cfg_lsb_first | input | 1 | 1: first bit received is bit 0 |
| cfg_start | input | 1 | Start/continue reception; clearing stops at the next byte boundary |
| ovr_clr | input | 1 | Write-1 clear of `rx_ovr` |
| sck_in | input | 1 | External serial clock (idle high) |
| sdi | input | 1 | Serial data input |
| sck_out | output | 1 | Generated serial clock, idle high |
| sck_oe | output | 1 | Output enable for `sck_out` (internal clock selected) |
| rx_data | output | DATA_W | Receive buffer |
| rx_valid | output | 1 | Receive buffer full |
| rx_ready | input | 1 | Consumer accepts `rx_data` when `rx_valid` is high |
| irq | output | 1 | One-cycle pulse per byte stored |
| busy | output | 1 | Reception in progress |
| shifting | output | 1 | First to eighth falling edge of the current byte |
| rx_ovr | output | 1 | Sticky overrun error (external clock) |

## Verification
The hardest situation to reach is the clock park at its boundary. A read must arrive while `sck_out` is parked, and the gap to the next falling edge must be measured. The bench plays a remote sender that changes `sdi` at each falling edge of `sck_out` it sees. It leaves the buffer unread for fifty cycles while counting edges, then reads, and counts the cycles until the next falling edge.

The overrun is reached by sending two external-clock bytes back to back with `rx_ready` held low. In a separate run, `cfg_start` is cleared after the second falling edge of a byte, to show that the byte still completes.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam logic [1:0] MODE_RX = 2'b01;

  typedef struct packed {
    logic rise;
    logic fall;
  } sck_evt_t;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RST}};
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ssr_clkgen.sv
module ssr_clkgen
  import ssr_pkg::*;
#(
  parameter int HALF = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  output logic     sck_o,
  output sck_evt_t evt
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt;
  logic          sck_q;
  logic          hold;
  logic          tick;

  // parking only happens at the high level
  assign hold = sck_q && !run;
  assign tick = !hold && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sck_q <= 1'b1;
    end else if (hold) begin
      cnt <= '0;
    end else if (tick) begin
      cnt   <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign sck_o    = sck_q;
  assign evt.fall = tick && sck_q;
  assign evt.rise = tick && !sck_q;
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter
  import ssr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sck_evt_t          evt,
  input  logic              sdi,
  input  logic              lsb_first,
  input  logic              may_start,
  output logic              in_byte,
  output logic              shifting,
  output logic              done,
  output logic [DATA_W-1:0] data
);
  localparam int CW = $clog2(DATA_W + 1);

  logic [CW-1:0]     fcnt;
  logic [CW-1:0]     bcnt;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] sh_nxt;

  always_comb begin
    if (lsb_first) sh_nxt = {sdi, sh[DATA_W-1:1]};
    else           sh_nxt = {sh[DATA_W-2:0], sdi};
  end

  assign in_byte  = (fcnt != '0);
  assign shifting = in_byte && (fcnt != CW'(DATA_W));
  assign done     = evt.rise && in_byte && (bcnt == CW'(DATA_W - 1));
  assign data     = sh_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
      bcnt <= '0;
      sh   <= '0;
    end else begin
      if (evt.fall) begin
        if (!in_byte && may_start)             fcnt <= CW'(1);
        else if (in_byte && fcnt != CW'(DATA_W)) fcnt <= fcnt + 1'b1;
      end
      if (evt.rise && in_byte) begin
        sh <= sh_nxt;
        if (bcnt == CW'(DATA_W - 1)) begin
          bcnt <= '0;
          fcnt <= '0;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ssr_rx.sv
module ssr_rx
  import ssr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_ext_clk,
  input  logic              cfg_lsb_first,
  input  logic              cfg_start,
  input  logic              ovr_clr,
  input  logic              sck_in,
  input  logic              sdi,
  output logic              sck_out,
  output logic              sck_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              irq,
  output logic              busy,
  output logic              rx_ovr
  ,output logic             shifting
);
  logic [1:0]        pins_s;
  logic              sck_prev;
  sck_evt_t          ext_evt, int_evt, evt;
  logic              enable, may_start, gen_run;
  logic              in_byte, done;
  logic [DATA_W-1:0] byte_data;
  logic              full_q, irq_q, ovr_q, busy_q;
  logic              rd, space;

  assign enable = cfg_start && (cfg_mode == MODE_RX);

  ssr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck_in, sdi}), .q(pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b1;
    else        sck_prev <= pins_s[1];
  end

  assign ext_evt.rise = pins_s[1] && !sck_prev;
  assign ext_evt.fall = !pins_s[1] && sck_prev;

  assign gen_run = !cfg_ext_clk && (in_byte || (enable && !full_q));

  ssr_clkgen #(.HALF(HALF)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(gen_run), .sck_o(sck_out), .evt(int_evt)
  );

  assign evt       = cfg_ext_clk ? ext_evt : int_evt;
  assign may_start = enable && (cfg_ext_clk || !full_q);

  ssr_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sdi(pins_s[0]),
    .lsb_first(cfg_lsb_first), .may_start(may_start),
    .in_byte(in_byte), .shifting(shifting), .done(done), .data(byte_data)
  );

  assign rd    = full_q && rx_ready;
  assign space = !full_q || rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
      ovr_q   <= 1'b0;
      busy_q  <= 1'b0;
      rx_data <= '0;
    end else begin
      irq_q <= done && space;
      if (done && space) begin
        rx_data <= byte_data;
        full_q  <= 1'b1;
      end else if (rd) begin
        full_q <= 1'b0;
      end
      if (done && !space) ovr_q <= 1'b1;
      else if (ovr_clr)   ovr_q <= 1'b0;
      if (in_byte)                busy_q <= 1'b1;
      else if (!enable)           busy_q <= 1'b0;
    end
  end

  assign rx_valid = full_q;
  assign irq      = irq_q;
  assign rx_ovr   = ovr_q;
  assign busy     = busy_q || in_byte;
  assign sck_oe   = !cfg_ext_clk;
endmodule

// File: rtl/ssr_rx_chk.sv
module ssr_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_mode,
  input logic              cfg_ext_clk,
  input logic              sck_out,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              irq,
  input logic              busy,
  input logic              shifting,
  input logic              rx_ovr
);
  // R1
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode != 2'b01 && !busy) |=> !busy);

  // R5
  shift_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |-> busy);

  // R6
  irq_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rx_valid);

  // R7
  hold_until_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R7
  clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_valid) |-> $past(rx_ready));

  // R8
  park_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ext_clk && rx_valid && sck_out) |=> sck_out);

  // R9
  ovr_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_valid));
endmodule

bind ssr_rx ssr_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_ext_clk(cfg_ext_clk),
  .sck_out(sck_out), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .irq(irq), .busy(busy), .shifting(shifting),
  .rx_ovr(rx_ovr)
);

// File: tb/tb_ssr_rx.sv
module tb_ssr_rx;
  localparam int HALF = 4;
  localparam int EH   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b01;
  logic       cfg_ext_clk = 1'b0;
  logic       cfg_lsb_first = 1'b0;
  logic       cfg_start = 1'b0;
  logic       ovr_clr = 1'b0;
  logic       sck_in = 1'b1;
  logic       sdi = 1'b0;
  logic       rx_ready = 1'b0;
  logic       sck_out, sck_oe, rx_valid, irq, busy, shifting, rx_ovr;
  logic [7:0] rx_data;

  int checks = 0;
  int fails  = 0;
  int irq_cnt = 0;

  always #2.5 clk = ~clk;

  ssr_rx #(.DATA_W(8), .HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_ext_clk(cfg_ext_clk),
    .cfg_lsb_first(cfg_lsb_first), .cfg_start(cfg_start), .ovr_clr(ovr_clr),
    .sck_in(sck_in), .sdi(sdi), .sck_out(sck_out), .sck_oe(sck_oe),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq),
    .busy(busy), .rx_ovr(rx_ovr), .shifting(shifting)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_valid(input int limit);
    for (int i = 0; i < limit && !rx_valid; i++) @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] exp, input string tag);
    @(negedge clk);
    check(rx_valid === 1'b1, {tag, " R7 valid before read"}, rx_valid, 1);
    check(rx_data === exp, {tag, " data"}, rx_data, exp);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    check(rx_valid === 1'b0, "R7 valid cleared by read", rx_valid, 0);
  endtask

  // remote sender for the generated clock: new bit after each falling edge
  task automatic int_byte(input logic [7:0] v, input bit lsb, input int stop_after,
                          output int first_fall);
    int n = 0;
    int cyc = 0;
    logic prev = sck_out;
    first_fall = -1;
    while (n < 8 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (prev && !sck_out) begin
        if (n == 0) first_fall = cyc;
        sdi = lsb ? v[n] : v[7-n];
        n++;
        if (stop_after != 0 && n == stop_after) cfg_start = 1'b0;
      end
      prev = sck_out;
    end
  endtask

  // remote master on sck_in
  task automatic ext_byte(input logic [7:0] v, input bit lsb, input bit chk, input int stop_after);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sck_in = 1'b0;
      sdi = lsb ? v[i] : v[7-i];
      repeat (5) @(negedge clk);
      if (chk && i == 0) begin
        check(shifting === 1'b1, "R5 shifting after first fall", shifting, 1);
        check(busy === 1'b1, "R4 busy after first fall", busy, 1);
      end
      if (chk && i == 7) check(shifting === 1'b0, "R5 shifting low after eighth fall", shifting, 0);
      if (stop_after != 0 && i + 1 == stop_after) cfg_start = 1'b0;
      repeat (EH - 5) @(negedge clk);
      sck_in = 1'b1;
      repeat (EH) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(rx_valid === 1'b0 && irq === 1'b0 && busy === 1'b0, "R11 reset flags", {rx_valid, irq, busy}, 0);
    check(shifting === 1'b0 && rx_ovr === 1'b0, "R11 reset shift/ovr", {shifting, rx_ovr}, 0);
    check(sck_out === 1'b1, "R11 reset sck_out", sck_out, 1);
  endtask

  task automatic t_wrong_mode();
    int falls = 0;
    cfg_mode = 2'b10;
    cfg_start = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!sck_out || busy) falls++;
    end
    check(falls == 0, "R1 no activity outside receive mode", falls, 0);
    check(rx_valid === 1'b0, "R1 nothing received", rx_valid, 0);
    cfg_start = 1'b0;
    cfg_mode = 2'b01;
  endtask

  task automatic t_int_msb_park();
    int ff;
    int edges = 0;
    int lat = 0;
    int irq0 = irq_cnt;
    cfg_ext_clk = 1'b0;
    cfg_lsb_first = 1'b0;
    @(negedge clk);
    cfg_start = 1'b1;
    int_byte(8'hA5, 1'b0, 0, ff);
    check(ff > 0 && ff <= 2*HALF, "R4 first generated fall latency", ff, 2*HALF);
    wait_valid(40);
    check(rx_valid === 1'b1 && rx_data === 8'hA5, "R2 msb-first byte", rx_data, 8'hA5);
    @(negedge clk);
    check(irq_cnt == irq0 + 1, "R6 one irq per byte", irq_cnt - irq0, 1);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!sck_out) edges++;
    end
    check(edges == 0, "R8 clock parked high while full", edges, 0);
    do_read(8'hA5, "R8");
    // clock resumes; stop request lands inside the next byte
    lat = 1;
    while (sck_out && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check(lat <= 2*HALF + 1, "R8 resume latency after read", lat, 2*HALF + 1);
    begin
      logic [7:0] v = 8'h3C;
      int n = 1;
      logic prev = sck_out;
      sdi = v[7];
      while (n < 8) begin
        @(negedge clk);
        if (prev && !sck_out) begin
          sdi = v[7-n];
          n++;
          if (n == 2) cfg_start = 1'b0;
        end
        prev = sck_out;
      end
    end
    wait_valid(40);
    repeat (3) @(negedge clk);
    check(rx_data === 8'h3C, "R10 byte in flight completes", rx_data, 8'h3C);
    check(busy === 1'b0, "R10 busy falls after stop", busy, 1'b0);
    do_read(8'h3C, "R10");
    edges = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!sck_out || rx_valid) edges++;
    end
    check(edges == 0, "R10 no further bytes after stop", edges, 0);
  endtask

  task automatic t_int_lsb();
    int ff;
    cfg_ext_clk = 1'b0;
    cfg_lsb_first = 1'b1;
    @(negedge clk);
    cfg_start = 1'b1;
    int_byte(8'h1E, 1'b1, 1, ff);
    wait_valid(40);
    check(rx_data === 8'h1E, "R3 lsb-first byte (internal clock)", rx_data, 8'h1E);
    do_read(8'h1E, "R3");
    cfg_lsb_first = 1'b0;
  endtask

  task automatic t_ext();
    int irq0;
    cfg_ext_clk = 1'b1;
    cfg_lsb_first = 1'b0;
    @(negedge clk);
    cfg_start = 1'b1;
    repeat (10) @(negedge clk);
    check(busy === 1'b0, "R4 busy waits for first fall", busy, 0);
    ext_byte(8'hC3, 1'b0, 1'b1, 0);
    check(rx_valid === 1'b1 && rx_data === 8'hC3, "R2 msb-first byte (external clock)", rx_data, 8'hC3);
    do_read(8'hC3, "R2");
    cfg_lsb_first = 1'b1;
    ext_byte(8'h6D, 1'b1, 1'b0, 0);
    check(rx_data === 8'h6D, "R3 lsb-first byte (external clock)", rx_data, 8'h6D);
    do_read(8'h6D, "R3");
    cfg_lsb_first = 1'b0;
    irq0 = irq_cnt;
    ext_byte(8'h11, 1'b0, 1'b0, 0);
    ext_byte(8'h22, 1'b0, 1'b0, 0);
    check(rx_ovr === 1'b1, "R9 overrun flagged", rx_ovr, 1);
    check(rx_valid === 1'b1 && rx_data === 8'h11, "R9 old byte kept", rx_data, 8'h11);
    check(irq_cnt == irq0 + 1, "R9 no irq for dropped byte", irq_cnt - irq0, 1);
    repeat (20) @(negedge clk);
    check(rx_ovr === 1'b1, "R9 overrun sticky", rx_ovr, 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    @(negedge clk);
    check(rx_ovr === 1'b0, "R9 write-1 clear", rx_ovr, 0);
    do_read(8'h11, "R9");
    ext_byte(8'h5A, 1'b0, 1'b0, 3);
    check(rx_data === 8'h5A, "R10 external byte completes after stop", rx_data, 8'h5A);
    check(busy === 1'b0, "R10 external busy falls", busy, 0);
    do_read(8'h5A, "R10");
    ext_byte(8'hFF, 1'b0, 1'b0, 0);
    check(rx_valid === 1'b0 && busy === 1'b0, "R10 ignored after stop", {rx_valid, busy}, 0);
    cfg_ext_clk = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wrong_mode();
    t_int_msb_park();
    t_int_lsb();
    t_ext();
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule